// File: doc/BRIEF.md
# Two-Step Large-Radix Montgomery Reducer

This block reduces a double-width product modulo a prime of the special shape q = 2^(32K)·m − 1, where the multiplier m fits in K 32-bit words. Because q is congruent to −1 modulo 2^(32K), the Montgomery constant for a radix of 2^(32K) is simply 1. The usual 2K single-word reduction rounds therefore collapse into two wide rounds. Each wide round replaces the current value c by (c >> 32K) + (c mod 2^(32K))·m. The result is congruent to c·2^(−64K) mod q and lies in [0, 2q), so no final subtraction is needed.

A host holds m on a static bus and pulses `start`. The block then fetches the 4K input words one per cycle, least significant first, through a word-wide read port. The data must answer combinationally in the same cycle. Each wide round runs as K rows of K products, one product per cycle. Every product is a fused multiply-add-add of 32-bit words: (hi, lo) = a·b + x + y. That sum never leaves 64 bits. A word-serial carry chain then adds the partial sum to the shifted upper words. The 2K result words stream out on consecutive cycles, least significant first.

Top module: `lrr_reducer`

## Requirements
- R1: In the cycle after reset, `busy`, `out_valid` and `out_last` are all 0.
- R2: After `start` is accepted in idle, `rd_addr` takes the values 0, 1, …, 4K−1 on 4K consecutive cycles. The first of these cycles is the one after acceptance. The word returned on `rd_data` at address a is input word a, and word 0 is the least significant.
- R3: The result z, formed from the output words with the first word least significant, satisfies z·2^(64K) ≡ c (mod q), where q = 2^(32K)·m − 1.
- R4: For every input 0 ≤ c ≤ (2q−1)^2 with 4q < 2^(64K), the result satisfies z < 2q. This includes the extreme c = (2q−1)^2, and no carry leaves the final word of either addition chain.
- R5: The result is emitted as 2K words on consecutive cycles with `out_valid` high, least significant word first. `out_last` is high only with the final word.
- R6: The first output word appears 9K + 2K² cycles after the clock edge that accepts `start`.
- R7: A `start` pulse while the block is busy is ignored. The result and the output timing of the running operation are unchanged.
- R8: `busy` is high from the cycle after acceptance through the cycle of the last output word. It is low in the next cycle.
- R9: The result is congruent modulo q to the result of 2K rounds of radix-2^32 Montgomery reduction of the same input. Each of those rounds computes c ← (c + (c mod 2^32)·q) / 2^32.
- R10: A multiplier m with one of its words equal to zero gives correct results under R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reduction when idle |
| m_val | input | 32K | Multiplier m of the modulus, held stable during an operation |
| rd_addr | output | clog2(4K) | Index of the input word being fetched |
| rd_data | input | 32 | Input word at `rd_addr`, returned in the same cycle |
| busy | output | 1 | Operation in progress |
| out_valid | output | 1 | `out_word` carries a result word |
| out_last | output | 1 | Marks the most significant result word |
| out_word | output | 32 | Result word |

## Verification
The hardest case to reach from the ports is an input near the top of the permitted range. There, the intermediate value after the first round fills its top word and the bound z < 2q is tight. Random inputs almost never land there. The stimulus therefore drives c = (2q−1)^2 directly, with m at its largest legal value and with m containing a zero word. A `start` pulse is also injected in the middle of a running operation, to show that it neither restarts the fetch nor shifts the output timing.

// File: rtl/lrr_pkg.sv
package lrr_pkg;
    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t hi;
        word_t lo;
    } wpair_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_MUL1,
        PH_ADD1,
        PH_MUL2,
        PH_ADD2,
        PH_EMIT
    } phase_t;

    // a*b + x + y always fits in two words: (2^32-1)^2 + 2(2^32-1) < 2^64
    function automatic wpair_t mul_add_add(word_t a, word_t b, word_t x, word_t y);
        logic [2*WORD_W-1:0] p;
        p = {{WORD_W{1'b0}}, a} * {{WORD_W{1'b0}}, b}
          + {{WORD_W{1'b0}}, x} + {{WORD_W{1'b0}}, y};
        return wpair_t'(p);
    endfunction
endpackage

// File: rtl/lrr_mac.sv
module lrr_mac
    import lrr_pkg::*;
(
    input  word_t  a,
    input  word_t  b,
    input  word_t  x,
    input  word_t  y,
    output wpair_t res
);
    assign res = mul_add_add(a, b, x, y);
endmodule

// File: rtl/lrr_addc.sv
module lrr_addc
    import lrr_pkg::*;
(
    input  word_t a,
    input  word_t b,
    input  logic  cin,
    output word_t sum,
    output logic  cout
);
    logic [WORD_W:0] full;
    assign full = {1'b0, a} + {1'b0, b} + {{WORD_W{1'b0}}, cin};
    assign sum  = full[WORD_W-1:0];
    assign cout = full[WORD_W];
endmodule

// File: rtl/lrr_ctrl.sv
module lrr_ctrl
    import lrr_pkg::*;
#(
    parameter int K = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output phase_t          phase,
    output logic [CW-1:0]   w,
    output logic [IW-1:0]   i,
    output logic [IW-1:0]   j,
    output logic            clr_acc
);
    localparam int CW = $clog2(4 * K);
    localparam int IW = (K > 1) ? $clog2(K) : 1;

    logic row_end, grid_end;
    assign row_end  = (int'(j) == K - 1);
    assign grid_end = row_end && (int'(i) == K - 1);

    assign clr_acc = (phase == PH_LOAD && int'(w) == 4 * K - 1) ||
                     (phase == PH_ADD1 && int'(w) == 3 * K - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            w     <= '0;
            i     <= '0;
            j     <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_LOAD;
                        w     <= '0;
                    end
                end
                PH_LOAD: begin
                    if (int'(w) == 4 * K - 1) begin
                        phase <= PH_MUL1;
                        w     <= '0;
                        i     <= '0;
                        j     <= '0;
                    end else begin
                        w <= w + 1'b1;
                    end
                end
                PH_MUL1, PH_MUL2: begin
                    if (row_end) begin
                        j <= '0;
                        if (grid_end) begin
                            i     <= '0;
                            w     <= '0;
                            phase <= (phase == PH_MUL1) ? PH_ADD1 : PH_ADD2;
                        end else begin
                            i <= i + 1'b1;
                        end
                    end else begin
                        j <= j + 1'b1;
                    end
                end
                PH_ADD1: begin
                    if (int'(w) == 3 * K - 1) begin
                        phase <= PH_MUL2;
                        w     <= '0;
                    end else begin
                        w <= w + 1'b1;
                    end
                end
                PH_ADD2: begin
                    if (int'(w) == 2 * K - 1) begin
                        phase <= PH_EMIT;
                        w     <= '0;
                    end else begin
                        w <= w + 1'b1;
                    end
                end
                PH_EMIT: begin
                    if (int'(w) == 2 * K - 1) begin
                        phase <= PH_IDLE;
                        w     <= '0;
                    end else begin
                        w <= w + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2: fetch addresses advance by one each load cycle
    assert_load_step_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD && int'(w) != 4 * K - 1) |=> (phase == PH_LOAD && w == $past(w) + 1'b1));

    // R7: a start seen mid-operation never re-enters the fetch phase
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (start && phase != PH_IDLE && phase != PH_LOAD) |=> (phase != PH_LOAD));
endmodule

// File: rtl/lrr_reducer.sv
module lrr_reducer
    import lrr_pkg::*;
#(
    parameter int K = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [32*K-1:0]         m_val,
    output logic [$clog2(4*K)-1:0]  rd_addr,
    input  logic [31:0]             rd_data,
    output logic                    busy,
    output logic                    out_valid,
    output logic                    out_last,
    output logic [31:0]             out_word
);
    localparam int NW  = 4 * K;
    localparam int NC  = 2 * K;
    localparam int AW  = $clog2(NW);
    localparam int CAW = $clog2(NC);
    localparam int IW  = (K > 1) ? $clog2(K) : 1;

    phase_t          phase;
    logic [AW-1:0]   w;
    logic [IW-1:0]   i, j;
    logic            clr_acc;

    word_t work [NW];
    word_t acc  [NC];
    word_t m_w  [K];
    word_t t_q;
    logic  cy_q;

    genvar g;
    generate
        for (g = 0; g < K; g++) begin : g_msplit
            assign m_w[g] = m_val[g*WORD_W +: WORD_W];
        end
    endgenerate

    lrr_ctrl #(.K(K)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .phase   (phase),
        .w       (w),
        .i       (i),
        .j       (j),
        .clr_acc (clr_acc)
    );

    // product path
    logic [CAW-1:0] idx_ij, idx_top;
    word_t          mac_x, mac_y;
    wpair_t         mac_res;
    logic           in_mul;

    assign in_mul  = (phase == PH_MUL1) || (phase == PH_MUL2);
    assign idx_ij  = CAW'(i) + CAW'(j);
    assign idx_top = CAW'(i) + CAW'(K);
    assign mac_x   = (j == '0) ? '0 : t_q;
    assign mac_y   = acc[idx_ij];

    lrr_mac u_mac (
        .a   (work[i]),
        .b   (m_w[j]),
        .x   (mac_x),
        .y   (mac_y),
        .res (mac_res)
    );

    // carry chain path
    logic [AW-1:0] up_idx;
    word_t         add_a, add_b, add_sum;
    logic          add_cin, add_cout, in_add, add_last;

    assign in_add   = (phase == PH_ADD1) || (phase == PH_ADD2);
    assign up_idx   = (int'(w) < 3 * K) ? AW'(int'(w) + K) : '0;
    assign add_a    = work[up_idx];
    assign add_b    = (int'(w) < NC) ? acc[CAW'(w)] : '0;
    assign add_cin  = (w == '0) ? 1'b0 : cy_q;
    assign add_last = (phase == PH_ADD1 && int'(w) == 3 * K - 1) ||
                      (phase == PH_ADD2 && int'(w) == NC - 1);

    lrr_addc u_addc (
        .a    (add_a),
        .b    (add_b),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q  <= '0;
            cy_q <= 1'b0;
            for (int n = 0; n < NW; n++) work[n] <= '0;
            for (int n = 0; n < NC; n++) acc[n]  <= '0;
        end else begin
            if (phase == PH_LOAD) begin
                work[w] <= rd_data;
            end
            if (clr_acc) begin
                for (int n = 0; n < NC; n++) acc[n] <= '0;
            end else if (in_mul) begin
                acc[idx_ij] <= mac_res.lo;
                t_q         <= mac_res.hi;
                if (int'(j) == K - 1) begin
                    acc[idx_top] <= mac_res.hi;
                end
            end
            if (in_add) begin
                work[w] <= add_sum;
                cy_q    <= add_cout;
            end
        end
    end

    assign rd_addr   = (phase == PH_LOAD) ? w : '0;
    assign busy      = (phase != PH_IDLE);
    assign out_valid = (phase == PH_EMIT);
    assign out_last  = (phase == PH_EMIT) && (int'(w) == NC - 1);
    assign out_word  = (phase == PH_EMIT) ? work[w] : '0;

    // R4: in-range inputs never carry out of either addition chain
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        add_last |-> !add_cout);

    // R5: the last marker only accompanies a valid word
    assert_last_valid_R5: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R5: result words run back to back until the last one
    assert_emit_run_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

    // R8: busy covers every output word and drops right after the last
    assert_busy_cover_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);
    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (rst)
        out_last |=> !busy);
endmodule

// File: tb/lrr_reducer_tb.sv
module lrr_reducer_tb;
    localparam int K   = 2;
    localparam int NW  = 4 * K;
    localparam int NC  = 2 * K;
    localparam int LAT = 9 * K + 2 * K * K;

    typedef logic [511:0] big_t;
    typedef struct {
        big_t c;
        big_t q;
        big_t zref;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [32*K-1:0] m_val = '0;
    logic [$clog2(NW)-1:0] rd_addr;
    logic [31:0] rd_data;
    logic busy, out_valid, out_last;
    logic [31:0] out_word;
    logic [31:0] cmem [NW];

    int n_checks = 0;
    int n_fail   = 0;
    item_t sb [$];

    always #4 clk = ~clk;

    always_comb rd_data = cmem[rd_addr];

    lrr_reducer #(.K(K)) u_dut (
        .clk(clk), .rst(rst), .start(start), .m_val(m_val),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .out_valid(out_valid), .out_last(out_last), .out_word(out_word)
    );

    task automatic check(input bit ok, input string req, input big_t act, input big_t exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic big_t serial_ref(input big_t c, input big_t q);
        big_t x = c;
        for (int r = 0; r < NC; r++) begin
            x = (x + big_t'(x[31:0]) * q) >> 32;
        end
        return x;
    endfunction

    // monitor: collects result words and compares against the scoreboard
    big_t acc_z = '0;
    int   nword = 0;
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            acc_z = acc_z | (big_t'(out_word) << (32 * nword));
            nword++;
            if (out_last) begin
                item_t it;
                check(nword == NC, "R5 word count", big_t'(nword), big_t'(NC));
                if (sb.size() == 0) begin
                    check(1'b0, "R5 unexpected result", acc_z, '0);
                end else begin
                    it = sb.pop_front();
                    check(((acc_z << (32 * NC)) % it.q) == (it.c % it.q), "R3 congruence",
                          (acc_z << (32 * NC)) % it.q, it.c % it.q);
                    check(acc_z < 2 * it.q, "R4 below 2q", acc_z, 2 * it.q);
                    check((acc_z % it.q) == (it.zref % it.q), "R9 serial agreement",
                          acc_z % it.q, it.zref % it.q);
                end
                acc_z = '0;
                nword = 0;
            end
        end
    end

    task automatic run_op(input logic [32*K-1:0] mm, input big_t cc, input bit poke, input string tag);
        big_t q;
        item_t it;
        int n;
        q = (big_t'(mm) << (32 * K)) - 1;
        for (int a = 0; a < NW; a++) cmem[a] = cc[32*a +: 32];
        it.c = cc; it.q = q; it.zref = serial_ref(cc, q);
        sb.push_back(it);
        @(negedge clk);
        m_val = mm;
        start = 1'b1;
        @(posedge clk);
        n = 0;
        forever begin
            @(negedge clk);
            start = (poke && n == 10);
            if (out_valid) break;
            if (n < NW) begin
                check(rd_addr == n[$clog2(NW)-1:0], "R2 fetch order", big_t'(rd_addr), big_t'(n));
            end
            if (n == 0) check(busy == 1'b1, "R8 busy after start", big_t'(busy), 1);
            n++;
            if (n > 4 * LAT) break;
        end
        check(n == LAT, {"R6 latency ", tag}, big_t'(n), big_t'(LAT));
        while (!out_last) @(negedge clk);
        @(negedge clk);
        check(!busy && !out_valid, "R8 idle after last", big_t'({busy, out_valid}), 0);
    endtask

    function automatic big_t rnd_c(input big_t q);
        big_t r = '0;
        big_t lim;
        for (int a = 0; a < NW; a++) r = r | (big_t'($urandom) << (32 * a));
        lim = (2 * q - 1) * (2 * q - 1) + 1;
        return r % lim;
    endfunction

    function automatic big_t max_c(input logic [32*K-1:0] mm);
        big_t q = (big_t'(mm) << (32 * K)) - 1;
        return (2 * q - 1) * (2 * q - 1);
    endfunction

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                check(1'b0, "watchdog", big_t'(cyc), 0);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] m_big, m_zlo, m_zhi, m_mid;
        for (int a = 0; a < NW; a++) cmem[a] = '0;
        m_big = 64'h3FFF_FFFF_FFFF_FFFF;
        m_zlo = 64'h2345_6789_0000_0000;
        m_zhi = 64'h0000_0000_9ABC_DEF1;
        m_mid = 64'h1D2C_3B4A_5968_7785;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !out_valid && !out_last, "R1 reset state",
              big_t'({busy, out_valid, out_last}), 0);

        run_op(64'd1, '0, 1'b0, "zero input");
        run_op(64'd1, max_c(64'd1), 1'b0, "m=1 max");
        run_op(m_big, max_c(m_big), 1'b0, "R4 extreme");
        run_op(m_mid, rnd_c((big_t'(m_mid) << 64) - 1), 1'b0, "random a");
        run_op(m_mid, rnd_c((big_t'(m_mid) << 64) - 1), 1'b0, "random b");
        run_op(m_zlo, max_c(m_zlo), 1'b0, "R10 zero low word max");
        run_op(m_zlo, rnd_c((big_t'(m_zlo) << 64) - 1), 1'b0, "R10 zero low word");
        run_op(m_zhi, rnd_c((big_t'(m_zhi) << 64) - 1), 1'b0, "R10 zero high word");
        run_op(m_big, rnd_c((big_t'(m_big) << 64) - 1), 1'b1, "R7 start while busy");
        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R7 no extra result", big_t'(sb.size()), 0);
        check(!busy, "R7 no restart", big_t'(busy), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule